// File: doc/BRIEF.md
# Camera pixel data word packer

This block sits behind a parallel camera data bus that carries up to 14 bits per pixel. On every clock edge where the pixel-valid input is high it takes one sample and places it into a 32-bit word for a downstream buffer. A 2-bit mode selects how many data bits each sample carries: 8, 10, 12 or 14.

In 8-bit mode each sample fills one byte lane, and four samples make a word. In the three wider modes each sample is zero-extended to a 16-bit halfword, and two halfwords make a word. The earliest sample always sits in the lowest lane. A completed word appears on the output together with a strobe that lasts one clock.

A start-of-frame clear input realigns the packing to the lowest lane and drops any partly filled word. It is also the only point, apart from reset, at which a new mode is taken on.

Top module: `cam_word_packer`

## Requirements
- R1: With active mode 2'b00, only pix_data[7:0] is packed; pix_data[13:8] has no effect on word_out.
- R2: In mode 2'b00, four accepted samples make one word: the 1st goes to bits 7:0, the 2nd to 15:8, the 3rd to 23:16 and the 4th to 31:24.
- R3: Modes 2'b01, 2'b10 and 2'b11 take pix_data[9:0], [11:0] and [13:0] respectively, zero-extended to a 16-bit halfword (bits 15:10, 15:12 and 15:14 read as zero).
- R4: In modes 2'b01, 2'b10 and 2'b11, two accepted samples make one word: the 1st goes to bits 15:0 and the 2nd to bits 31:16.
- R5: A sample is accepted only on a rising clock edge where pix_valid is 1 and sof_clr is 0; any other edge leaves the packing unchanged.
- R6: word_valid is 1 for exactly the one cycle after the edge that accepts the last sample of a word, and word_out changes only at that edge and holds its value at all other times.
- R7: An edge with sof_clr at 1 discards the partly filled word and the sample presented on that edge, so the next accepted sample lands in the lowest lane; that edge never raises word_valid.
- R8: mode_in is loaded into the active mode only on an edge where rst or sof_clr is 1; a change of mode_in at any other time has no effect.
- R9: Synchronous reset (rst at 1 on an edge) clears word_out to 0 and word_valid to 0, discards any partial word and loads mode_in.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| sof_clr | input | 1 | Start-of-frame clear; realigns lanes and loads mode_in |
| mode_in | input | 2 | Sample width select: 00=8, 01=10, 10=12, 11=14 bits |
| pix_valid | input | 1 | Sample on pix_data is valid this edge |
| pix_data | input | 14 | Camera data bus |
| word_out | output | 32 | Last completed packed word |
| word_valid | output | 1 | One-cycle strobe when word_out is updated |

## Verification
The packing is tried with data that has the upper bus bits set in 8-bit mode, which shows whether the unused bits leak into a byte lane. Samples are also sent with all ones in every wide mode, which shows whether each mode masks at its own width. Valid gaps and continuous valid runs separate counting by accepted samples from counting by clock edges, and continuous runs also show that the strobe repeats with the right period. Changes of mode_in in the middle of a frame, and a frame clear or reset part-way through a word, show whether the mode and lane alignment are taken only at the points the block allows.

// File: rtl/cwp_pkg.sv
package cwp_pkg;
   typedef enum logic [1:0] {
      CWP_W8  = 2'b00,
      CWP_W10 = 2'b01,
      CWP_W12 = 2'b10,
      CWP_W14 = 2'b11
   } cwp_mode_e;

   localparam int CWP_MODES = 4;
endpackage

// File: rtl/cwp_mode_hold.sv
module cwp_mode_hold
   import cwp_pkg::*;
(
   input  logic      clk,
   input  logic      rst,
   input  logic      sof_clr,
   input  logic [1:0] mode_in,
   output cwp_mode_e mode_q
);
   always_ff @(posedge clk) begin
      if (rst || sof_clr) mode_q <= cwp_mode_e'(mode_in);
   end
endmodule

// File: rtl/cwp_sample_fmt.sv
module cwp_sample_fmt
   import cwp_pkg::*;
#(
   parameter int DATA_W = 14,
   parameter int HALF_W = 16,
   parameter int BASE_W = 8,
   parameter int STEP_W = 2
) (
   input  cwp_mode_e         mode,
   input  logic [DATA_W-1:0] data,
   output logic [HALF_W-1:0] half
);
   logic [HALF_W-1:0] fmt [CWP_MODES];

   for (genvar m = 0; m < CWP_MODES; m++) begin : g_mode
      localparam int W = BASE_W + STEP_W * m;
      if (W > DATA_W || W > HALF_W) begin : g_bad
         $error("cwp_sample_fmt: mode width exceeds bus or halfword");
      end
      assign fmt[m] = HALF_W'(data[W-1:0]);
   end

   always_comb half = fmt[mode];
endmodule

// File: rtl/cwp_lane_seq.sv
module cwp_lane_seq #(
   parameter int LANES = 4,
   localparam int CNT_W = $clog2(LANES)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             clr,
   input  logic             take,
   input  logic             wide,
   output logic [CNT_W-1:0] cnt,
   output logic             last
);
   localparam logic [CNT_W-1:0] LAST_NARROW = CNT_W'(LANES - 1);
   localparam logic [CNT_W-1:0] LAST_WIDE   = CNT_W'(LANES / 2 - 1);

   always_comb last = wide ? (cnt == LAST_WIDE) : (cnt == LAST_NARROW);

   always_ff @(posedge clk) begin
      if (rst || clr)  cnt <= '0;
      else if (take)   cnt <= last ? '0 : cnt + 1'b1;
   end
endmodule

// File: rtl/cwp_word_asm.sv
module cwp_word_asm #(
   parameter int LANE_W = 8,
   parameter int LANES  = 4,
   localparam int HALF_W = 2 * LANE_W,
   localparam int WORD_W = LANES * LANE_W,
   localparam int CNT_W  = $clog2(LANES)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              take,
   input  logic              wide,
   input  logic              last,
   input  logic [CNT_W-1:0]  cnt,
   input  logic [HALF_W-1:0] half,
   output logic [WORD_W-1:0] word_out,
   output logic              word_valid
);
   logic [WORD_W-1:0] acc;
   logic [WORD_W-1:0] merged;

   for (genvar b = 0; b < LANES; b++) begin : g_lane
      logic              sel;
      logic [LANE_W-1:0] dat;
      assign sel = wide ? (cnt == CNT_W'(b / 2)) : (cnt == CNT_W'(b));
      assign dat = wide ? half[(b % 2) * LANE_W +: LANE_W] : half[LANE_W-1:0];
      assign merged[b*LANE_W +: LANE_W] = (take && sel) ? dat : acc[b*LANE_W +: LANE_W];
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         acc        <= '0;
         word_out   <= '0;
         word_valid <= 1'b0;
      end else begin
         acc        <= merged;
         word_valid <= take && last;
         if (take && last) word_out <= merged;
      end
   end
endmodule

// File: rtl/cam_word_packer.sv
module cam_word_packer
   import cwp_pkg::*;
#(
   parameter int DATA_W = 14,
   parameter int LANE_W = 8,
   parameter int LANES  = 4,
   parameter int STEP_W = 2,
   localparam int HALF_W = 2 * LANE_W,
   localparam int WORD_W = LANES * LANE_W,
   localparam int CNT_W  = $clog2(LANES)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              sof_clr,
   input  logic [1:0]        mode_in,
   input  logic              pix_valid,
   input  logic [DATA_W-1:0] pix_data,
   output logic [WORD_W-1:0] word_out,
   output logic              word_valid
);
   if (LANES != 4) begin : g_bad_lanes
      $error("cam_word_packer: LANES must be 4 (four bytes or two halfwords)");
   end
   if (LANE_W + 3 * STEP_W != DATA_W) begin : g_bad_width
      $error("cam_word_packer: widest mode must equal DATA_W");
   end
   if (DATA_W > HALF_W) begin : g_bad_half
      $error("cam_word_packer: DATA_W exceeds halfword");
   end

   cwp_mode_e         mode_q;
   logic              take;
   logic              wide;
   logic              last;
   logic [CNT_W-1:0]  cnt;
   logic [HALF_W-1:0] half;

   assign take = pix_valid && !sof_clr;
   assign wide = (mode_q != CWP_W8);

   cwp_mode_hold u_mode (
      .clk(clk), .rst(rst), .sof_clr(sof_clr), .mode_in(mode_in), .mode_q(mode_q)
   );

   cwp_sample_fmt #(
      .DATA_W(DATA_W), .HALF_W(HALF_W), .BASE_W(LANE_W), .STEP_W(STEP_W)
   ) u_fmt (
      .mode(mode_q), .data(pix_data), .half(half)
   );

   cwp_lane_seq #(.LANES(LANES)) u_seq (
      .clk(clk), .rst(rst), .clr(sof_clr), .take(take), .wide(wide),
      .cnt(cnt), .last(last)
   );

   cwp_word_asm #(.LANE_W(LANE_W), .LANES(LANES)) u_asm (
      .clk(clk), .rst(rst), .take(take), .wide(wide), .last(last), .cnt(cnt),
      .half(half), .word_out(word_out), .word_valid(word_valid)
   );
endmodule

// File: rtl/cwp_checker.sv
module cwp_checker
   import cwp_pkg::*;
(
   input logic        clk,
   input logic        rst,
   input logic        sof_clr,
   input logic        pix_valid,
   input logic [31:0] word_out,
   input logic        word_valid,
   input cwp_mode_e   act_mode
);
   // R5: a strobe needs an accepted sample on the previous edge
   p_strobe_needs_sample_r5: assert property (@(posedge clk) disable iff (rst)
      word_valid |-> ($past(pix_valid) && !$past(sof_clr) && !$past(rst)));

   // R6: output word holds between strobes
   p_out_hold_r6: assert property (@(posedge clk) disable iff (rst)
      (!word_valid && !$past(rst)) |-> $stable(word_out));

   // R6: strobe is a single-cycle pulse (at least two samples per word)
   p_single_pulse_r6: assert property (@(posedge clk) disable iff (rst)
      word_valid |=> !word_valid);

   // R7: a frame clear never completes a word
   p_sof_no_strobe_r7: assert property (@(posedge clk) disable iff (rst)
      sof_clr |=> !word_valid);

   // R3: zero padding of both halfwords in the wide modes
   p_pad_zero_r3: assert property (@(posedge clk) disable iff (rst)
      (word_valid && act_mode == CWP_W10) |->
         (word_out[15:10] == 6'd0 && word_out[31:26] == 6'd0));
   p_pad_zero12_r3: assert property (@(posedge clk) disable iff (rst)
      (word_valid && act_mode == CWP_W12) |->
         (word_out[15:12] == 4'd0 && word_out[31:28] == 4'd0));
   p_pad_zero14_r3: assert property (@(posedge clk) disable iff (rst)
      (word_valid && act_mode == CWP_W14) |->
         (word_out[15:14] == 2'd0 && word_out[31:30] == 2'd0));
endmodule

bind cam_word_packer cwp_checker u_chk (
   .clk(clk), .rst(rst), .sof_clr(sof_clr), .pix_valid(pix_valid),
   .word_out(word_out), .word_valid(word_valid), .act_mode(mode_q)
);

// File: tb/tb_cam_word_packer.sv
`timescale 1ns/1ps
module tb_cam_word_packer;
   logic        clk = 1'b0;
   logic        rst;
   logic        sof_clr;
   logic [1:0]  mode_in;
   logic        pix_valid;
   logic [13:0] pix_data;
   logic [31:0] word_out;
   logic        word_valid;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   cam_word_packer dut (
      .clk(clk), .rst(rst), .sof_clr(sof_clr), .mode_in(mode_in),
      .pix_valid(pix_valid), .pix_data(pix_data),
      .word_out(word_out), .word_valid(word_valid)
   );

   typedef struct packed {
      logic [1:0]  m;
      logic        s;
      logic        v;
      logic [13:0] d;
      logic        ev;
      logic [31:0] ew;
   } vec_t;

   localparam int NV = 17;
   localparam vec_t VEC [NV] = '{
      '{2'd0, 1'b0, 1'b1, 14'h3F11, 1'b0, 32'h0},         // R1 upper bits set
      '{2'd0, 1'b0, 1'b1, 14'h3E22, 1'b0, 32'h0},         // R2
      '{2'd0, 1'b0, 1'b0, 14'h1FFF, 1'b0, 32'h0},         // R5 gap
      '{2'd0, 1'b0, 1'b1, 14'h0033, 1'b0, 32'h0},         // R2
      '{2'd0, 1'b0, 1'b1, 14'h2A44, 1'b1, 32'h44332211},  // R1 R2 R6
      '{2'd1, 1'b0, 1'b1, 14'h0055, 1'b0, 32'h44332211},  // R8 still 8-bit
      '{2'd1, 1'b1, 1'b1, 14'h0066, 1'b0, 32'h44332211},  // R7 R8 clear, load 01
      '{2'd1, 1'b0, 1'b1, 14'h3FFF, 1'b0, 32'h44332211},  // R3
      '{2'd1, 1'b0, 1'b1, 14'h1234, 1'b1, 32'h023403FF},  // R3 R4
      '{2'd2, 1'b1, 1'b0, 14'h0000, 1'b0, 32'h023403FF},  // R8 load 10
      '{2'd2, 1'b0, 1'b1, 14'h3ABC, 1'b0, 32'h023403FF},  // R3
      '{2'd2, 1'b0, 1'b1, 14'h2FFF, 1'b1, 32'h0FFF0ABC},  // R3 R4
      '{2'd3, 1'b1, 1'b0, 14'h0000, 1'b0, 32'h0FFF0ABC},  // R8 load 11
      '{2'd3, 1'b0, 1'b1, 14'h3FFF, 1'b0, 32'h0FFF0ABC},  // R3
      '{2'd3, 1'b0, 1'b1, 14'h2001, 1'b1, 32'h20013FFF},  // R4
      '{2'd3, 1'b0, 1'b1, 14'h1555, 1'b0, 32'h20013FFF},  // R6 hold
      '{2'd0, 1'b0, 1'b1, 14'h0AAA, 1'b1, 32'h0AAA1555}   // R8 mid-frame change ignored
   };

   task automatic step(input logic [1:0] m, input logic s, input logic r,
                       input logic v, input logic [13:0] d);
      @(negedge clk);
      mode_in = m; sof_clr = s; rst = r; pix_valid = v; pix_data = d;
      @(posedge clk);
      #2;
   endtask

   task automatic check(input logic ev, input logic [31:0] ew, input string tag);
      checks++;
      if (word_valid !== ev || word_out !== ew) begin
         errors++;
         $display("FAIL %s: got valid=%0b word=%08h, expected valid=%0b word=%08h",
                  tag, word_valid, word_out, ev, ew);
      end
   endtask

   initial begin
      rst = 1'b1; sof_clr = 1'b0; mode_in = 2'd0; pix_valid = 1'b0; pix_data = '0;
      step(2'd0, 1'b0, 1'b1, 1'b1, 14'h3FFF);
      step(2'd0, 1'b0, 1'b1, 1'b1, 14'h3FFF);
      check(1'b0, 32'h0, "R9 reset state");

      for (int i = 0; i < NV; i++) begin
         step(VEC[i].m, VEC[i].s, 1'b0, VEC[i].v, VEC[i].d);
         check(VEC[i].ev, VEC[i].ew, $sformatf("vector %0d (R1..R8 table)", i));
      end

      // R7: clear part-way through an 8-bit word
      step(2'd0, 1'b1, 1'b0, 1'b0, 14'h0);
      step(2'd0, 1'b0, 1'b0, 1'b1, 14'h00A1);
      step(2'd0, 1'b0, 1'b0, 1'b1, 14'h00A2);
      step(2'd0, 1'b1, 1'b0, 1'b1, 14'h00FF);
      check(1'b0, 32'h0AAA1555, "R7 clear edge no strobe");
      step(2'd0, 1'b0, 1'b0, 1'b1, 14'h0001);
      step(2'd0, 1'b0, 1'b0, 1'b1, 14'h0002);
      step(2'd0, 1'b0, 1'b0, 1'b1, 14'h0003);
      check(1'b0, 32'h0AAA1555, "R7 realigned, three samples");
      step(2'd0, 1'b0, 1'b0, 1'b1, 14'h0004);
      check(1'b1, 32'h04030201, "R7 realigned word");
      step(2'd0, 1'b0, 1'b0, 1'b0, 14'h0);
      check(1'b0, 32'h04030201, "R6 strobe one cycle");

      // R2 R6: continuous valid, two words back to back
      for (int k = 0; k < 8; k++) begin
         step(2'd0, 1'b0, 1'b0, 1'b1, 14'(8'h10 + k));
         if (k == 3)      check(1'b1, 32'h13121110, "R2 first of run");
         else if (k == 7) check(1'b1, 32'h17161514, "R2 second of run");
         else if (k < 3)  check(1'b0, 32'h04030201, "R6 no strobe mid word");
         else             check(1'b0, 32'h13121110, "R6 no strobe mid word");
      end

      // R9: reset part-way through a word, loads mode 01
      step(2'd0, 1'b0, 1'b0, 1'b1, 14'h0055);
      step(2'd1, 1'b0, 1'b1, 1'b1, 14'h0066);
      check(1'b0, 32'h0, "R9 reset mid word");
      step(2'd0, 1'b0, 1'b0, 1'b1, 14'h3FFF);
      check(1'b0, 32'h0, "R9 first halfword after reset");
      step(2'd0, 1'b0, 1'b0, 1'b1, 14'h0001);
      check(1'b1, 32'h000103FF, "R9 R8 mode loaded by reset");

      // R4 R5: wide mode with a valid gap between halves
      step(2'd0, 1'b0, 1'b0, 1'b1, 14'h0123);
      step(2'd0, 1'b0, 1'b0, 1'b0, 14'h03FF);
      check(1'b0, 32'h000103FF, "R5 gap in wide mode");
      step(2'd0, 1'b0, 1'b0, 1'b1, 14'h0321);
      check(1'b1, 32'h03210123, "R4 R5 word after gap");

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(20 * 200000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: got no completion, expected end of run");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule